// File: doc/BRIEF.md
# Pending-Interrupt Priority Scanner

This block recomputes, from scratch, which message-signalled interrupt should be serviced next. A single-cycle start pulse launches a full walk over a pending bitmap held in memory. The walk reads that bitmap one byte at a time. For every set bit it fetches a one-byte configuration entry for that interrupt, which carries the interrupt's priority and enable bit. When the walk is complete, the block reports the pending, enabled interrupt with the numerically lowest effective priority, together with that priority and a valid flag. A done pulse marks the end of the walk.

The caller supplies two base addresses: one for the bitmap and one for the configuration table. It also supplies the table size, written as the number of interrupt ID bits minus one, and a flag that chooses how the configured priority is mapped before comparison. All memory traffic goes through one byte-wide read port with a request/acknowledge handshake, and only one read is in flight at a time.

Top module: `lpi_pend_scanner`

## Requirements
- R1: While reset is held, and after it is released, `scan_done`, `win_valid` and `rd_req` are 0 and `win_prio` is 0xFF.
- R2: The bitmap holds 2^(`id_bits_m1`+1) bits. If that is 8192 bits or fewer, the start pulse is followed on the next clock by `scan_done` high, with `win_valid` 0, `win_prio` 0xFF and no memory read.
- R3: A scan reads the bitmap bytes at `pend_base` + k, for k running upward from 1024 through 2^(`id_bits_m1`-2)-1. Each byte is read exactly once. `rd_req` and `rd_addr` stay steady until `rd_ack`, and only one read is in flight.
- R4: Within a byte, set bits are taken from bit 0 upward. Bit b of byte k stands for ID 8·k+b. For each set bit, exactly one configuration byte is read, at `cfg_base` + (ID − 8192), so configuration reads come in ascending ID order.
- R5: Bit 0 of a configuration byte is its enable. A pending ID whose enable is 0 never wins.
- R6: With `sec_off` = 1, the effective priority is the configuration byte AND 0xFC.
- R7: With `sec_off` = 0, the effective priority is ((cfg AND 0xFC) >> 1) OR 0x80.
- R8: A candidate replaces the current winner only if its effective priority is strictly lower. On equal priority, the lower ID is kept.
- R9: `scan_done` is a one-cycle pulse issued after the last byte has been handled. At that point `win_id`, `win_prio` and `win_valid` describe the result, and they hold until the next accepted start. If nothing was pending and enabled, `win_valid` is 0 and `win_prio` is 0xFF.
- R10: A start pulse that arrives while a scan is running has no effect. The running scan keeps its bases, size and flag and finishes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_start | input | 1 | One-cycle pulse that begins a full rescan |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| cfg_base | input | ADDR_W | Byte address of the configuration table |
| id_bits_m1 | input | SIZE_W | Interrupt ID bits minus one; sets table size |
| sec_off | input | 1 | 1: priority used unshifted; 0: priority remapped |
| rd_req | output | 1 | Byte read request, held until acknowledged |
| rd_addr | output | ADDR_W | Byte read address |
| rd_ack | input | 1 | Read data is present on `rd_data` |
| rd_data | input | 8 | Byte returned by memory |
| win_id | output | ID_W | ID of the winning interrupt |
| win_prio | output | 8 | Effective priority of the winner, 0xFF if none |
| win_valid | output | 1 | A winner was found |
| scan_done | output | 1 | One-cycle pulse at scan completion |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a long walk. If the block were to accept it, the partial result would be quietly dropped and the walk restarted with other bases. To exercise this, the bench fires a second start, carrying a different flag and a different configuration base, a hundred cycles into a scan. It then checks that the final winner, the number of bitmap reads and the number of configuration reads all match the first request alone. Ties and the last-ID boundary are set up by placing two equal-priority IDs in one bitmap byte, and by setting the highest bit of the final byte.

// File: rtl/lpi_scan_pkg.sv
// Package: shared constants, FSM state type and the priority mapping
// used by the pending-interrupt priority scanner.
// Assumes message-signalled IDs start at 8192 and configuration bytes
// carry the priority in bits [7:2] and the enable in bit 0.
package lpi_scan_pkg;

    localparam int unsigned LPI_FIRST = 8192;
    localparam int unsigned LPI_BYTE0 = LPI_FIRST / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRD  = 2'd1,
        ST_PICK = 2'd2,
        ST_CRD  = 2'd3
    } scan_state_t;

    // Map a configuration byte to the effective priority used for comparison.
    function automatic logic [7:0] eff_prio(input logic [7:0] cfg, input logic sec_off);
        logic [7:0] raw;
        raw = cfg & 8'hFC;
        if (sec_off) begin
            eff_prio = raw;
        end else begin
            eff_prio = (raw >> 1) | 8'h80;
        end
    endfunction

endpackage

// File: rtl/lpi_byte_walker.sv
// Byte walker: holds the current bitmap byte index and the final index
// of the table. The table size comes from the ID-bits-minus-one field.
// Assumes the size input is stable in the cycle where load is high.
module lpi_byte_walker #(
    parameter int unsigned SIZE_W = 5,
    parameter int unsigned IDX_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              load,
    input  logic              step,
    input  logic              active,
    output logic              tbl_empty,
    output logic [IDX_W-1:0]  idx,
    output logic              at_last
);
    import lpi_scan_pkg::*;

    localparam int unsigned SH_W = SIZE_W + 1;

    logic [63:0]      tbl_bits;
    logic [IDX_W-1:0] last_c;
    logic [IDX_W-1:0] last_q;

    // Table size in bits, its last byte index and whether it covers any LPI.
    always_comb begin
        tbl_bits  = 64'd1 << ({1'b0, size_in} + SH_W'(1));
        last_c    = IDX_W'((tbl_bits >> 3) - 64'd1);
        tbl_empty = (tbl_bits <= 64'(LPI_FIRST));
    end

    // Index register: loads the first LPI byte, then advances on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            last_q <= '0;
        end else if (load) begin
            idx    <= IDX_W'(LPI_BYTE0);
            last_q <= last_c;
        end else if (step) begin
            idx <= idx + IDX_W'(1);
        end
    end

    assign at_last = (idx == last_q);

    assert_idx_in_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx >= IDX_W'(LPI_BYTE0)) && (idx <= last_q));

    assert_step_not_past_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_last);

endmodule

// File: rtl/lpi_bit_picker.sv
// Bit picker: stores the current pending byte and presents its lowest
// set bit. Each pop clears the presented bit.
// Assumes pop is only raised while at least one bit remains set.
module lpi_bit_picker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       pop,
    output logic       any,
    output logic [2:0] pos
);
    logic [7:0] bits_q;

    // Lowest set bit of the stored byte.
    always_comb begin
        pos = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (bits_q[i]) pos = 3'(i);
        end
    end

    assign any = |bits_q;

    // Byte register: loaded from memory, one bit cleared per pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (load) begin
            bits_q <= load_val;
        end else if (pop) begin
            bits_q <= bits_q & ~(8'h01 << pos);
        end
    end

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> any);

    assert_pop_clears_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !load) |=> $countones(bits_q) == $countones($past(bits_q)) - 1);

    assert_pop_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !load) |=> (bits_q & ((8'h01 << $past(pos)) - 8'h01)) == 8'h00);

endmodule

// File: rtl/lpi_best_track.sv
// Winner tracker: keeps the best enabled candidate seen in this scan.
// A candidate wins only on a strictly lower effective priority, so on
// a tie the earlier (lower) ID stays.
// Assumes candidates are offered in ascending ID order.
module lpi_best_track #(
    parameter int unsigned ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cand_en,
    input  logic [ID_W-1:0] cand_id,
    input  logic [7:0]      cand_cfg,
    input  logic            sec_off,
    output logic [ID_W-1:0] best_id,
    output logic [7:0]      best_prio,
    output logic            best_valid
);
    import lpi_scan_pkg::*;

    logic [7:0] cand_prio;
    logic       take;

    // Candidate priority and strict-less comparison against the winner.
    always_comb begin
        cand_prio = eff_prio(cand_cfg, sec_off);
        take      = cand_en && cand_cfg[0] && (cand_prio < best_prio);
    end

    // Winner registers: reset on clear, replaced when a candidate wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_id    <= '0;
            best_prio  <= 8'hFF;
            best_valid <= 1'b0;
        end else if (take) begin
            best_id    <= cand_id;
            best_prio  <= cand_prio;
            best_valid <= 1'b1;
        end
    end

    assert_valid_has_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> best_prio != 8'hFF);

    assert_prio_never_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> best_prio <= $past(best_prio));

    assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_en && !cand_cfg[0] && !clear) |=> $stable(best_id) && $stable(best_valid));

    assert_secure_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_en && !sec_off) |-> cand_prio[7]);

endmodule

// File: rtl/lpi_pend_scanner.sv
// Pending-interrupt priority scanner (top). On a start pulse it walks the
// pending bitmap byte by byte from the first LPI byte to the end of the
// table. For each set bit it reads that ID's configuration byte and keeps
// the lowest effective priority. It finishes with a one-cycle done pulse.
// Assumes a memory that answers every held request with one ack, and
// inputs other than scan_start that are steady in the start cycle.
module lpi_pend_scanner #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ID_W   = 32,
    parameter int unsigned SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] id_bits_m1,
    input  logic              sec_off,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic [ID_W-1:0]   win_id,
    output logic [7:0]        win_prio,
    output logic              win_valid,
    output logic              scan_done
);
    import lpi_scan_pkg::*;

    localparam int unsigned IDX_W = ID_W - 3;

    scan_state_t       state_q;
    logic [ADDR_W-1:0] pend_base_q;
    logic [ADDR_W-1:0] cfg_base_q;
    logic              sec_off_q;
    logic [ID_W-1:0]   cur_id_q;

    logic              accept;
    logic              tbl_empty;
    logic [IDX_W-1:0]  idx;
    logic              at_last;
    logic              walk_step;
    logic              bit_any;
    logic [2:0]        bit_pos;
    logic              bit_load;
    logic              bit_pop;
    logic              cand_en;

    assign accept    = (state_q == ST_IDLE) && scan_start;
    assign bit_load  = (state_q == ST_PRD) && rd_ack;
    assign bit_pop   = (state_q == ST_PICK) && bit_any;
    assign walk_step = (state_q == ST_PICK) && !bit_any && !at_last;
    assign cand_en   = (state_q == ST_CRD) && rd_ack;

    lpi_byte_walker #(
        .SIZE_W(SIZE_W),
        .IDX_W (IDX_W)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_in  (id_bits_m1),
        .load     (accept),
        .step     (walk_step),
        .active   (state_q != ST_IDLE),
        .tbl_empty(tbl_empty),
        .idx      (idx),
        .at_last  (at_last)
    );

    lpi_bit_picker u_picker (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bit_load),
        .load_val(rd_data),
        .pop     (bit_pop),
        .any     (bit_any),
        .pos     (bit_pos)
    );

    lpi_best_track #(
        .ID_W(ID_W)
    ) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .cand_en   (cand_en),
        .cand_id   (cur_id_q),
        .cand_cfg  (rd_data),
        .sec_off   (sec_off_q),
        .best_id   (win_id),
        .best_prio (win_prio),
        .best_valid(win_valid)
    );

    // Read port: one request per read state, address from the latched bases.
    always_comb begin
        rd_req  = (state_q == ST_PRD) || (state_q == ST_CRD);
        rd_addr = '0;
        if (state_q == ST_PRD) begin
            rd_addr = pend_base_q + ADDR_W'(idx);
        end else if (state_q == ST_CRD) begin
            rd_addr = cfg_base_q + ADDR_W'(cur_id_q - ID_W'(LPI_FIRST));
        end
    end

    // Sequencer: accepts start in idle, walks bytes and bits, raises done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_base_q <= '0;
            cfg_base_q  <= '0;
            sec_off_q   <= 1'b0;
            cur_id_q    <= '0;
            scan_done   <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (scan_start) begin
                        pend_base_q <= pend_base;
                        cfg_base_q  <= cfg_base;
                        sec_off_q   <= sec_off;
                        if (tbl_empty) begin
                            scan_done <= 1'b1;
                        end else begin
                            state_q <= ST_PRD;
                        end
                    end
                end
                ST_PRD: begin
                    if (rd_ack) state_q <= ST_PICK;
                end
                ST_PICK: begin
                    if (bit_any) begin
                        cur_id_q <= {idx, bit_pos};
                        state_q  <= ST_CRD;
                    end else if (at_last) begin
                        scan_done <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= ST_PRD;
                    end
                end
                ST_CRD: begin
                    if (rd_ack) state_q <= ST_PICK;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    assert_empty_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tbl_empty) |=> !rd_req && scan_done && !win_valid);

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_start && state_q != ST_IDLE) |=> $stable(pend_base_q) && $stable(cfg_base_q) && $stable(sec_off_q));

    assert_req_after_ack_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);

endmodule

// File: tb/lpi_pend_scanner_test.sv
// Bench for the pending-interrupt priority scanner: a vector table walked
// by one loop, then directed tests for reset, tiny tables and busy starts.
module lpi_pend_scanner_test;

    localparam logic [31:0] PB  = 32'h0001_0000;
    localparam logic [31:0] CB  = 32'h0010_0000;
    localparam logic [31:0] CB2 = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 1'b0;
    logic [31:0] pend_base = PB;
    logic [31:0] cfg_base = CB;
    logic [4:0]  id_bits_m1 = 5'd13;
    logic        sec_off = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack;
    logic [7:0]  rd_data;
    logic [31:0] win_id;
    logic [7:0]  win_prio;
    logic        win_valid;
    logic        scan_done;

    int n_checks = 0;
    int n_fail = 0;
    int pend_reads = 0;
    int cfg_reads = 0;
    int order_err = 0;
    int range_err = 0;
    longint last_cfg = -1;

    logic [7:0] mem [longint];

    always #10 clk = ~clk;

    lpi_pend_scanner uut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
        .pend_base(pend_base), .cfg_base(cfg_base), .id_bits_m1(id_bits_m1),
        .sec_off(sec_off), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .win_id(win_id),
        .win_prio(win_prio), .win_valid(win_valid), .scan_done(scan_done)
    );

    function automatic logic [7:0] rd(input longint a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Memory model: acknowledges a held request one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_data <= 8'h00;
        end else if (rd_req && !rd_ack) begin
            rd_ack  <= 1'b1;
            rd_data <= rd(longint'(rd_addr));
        end else begin
            rd_ack <= 1'b0;
        end
    end

    // Traffic monitor: counts reads by table and checks order and range.
    always @(posedge clk) begin
        if (rst_n && rd_req && rd_ack) begin
            if (rd_addr >= CB) begin
                cfg_reads <= cfg_reads + 1;
                if (longint'(rd_addr - CB) <= last_cfg) order_err <= order_err + 1;
                last_cfg <= longint'(rd_addr - CB);
            end else begin
                pend_reads <= pend_reads + 1;
                if (rd_addr < PB + 32'd1024) range_err <= range_err + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_irq(input logic [31:0] id, input logic [7:0] cfg);
        if (id != 0) begin
            mem[longint'(PB + id / 8)] = rd(longint'(PB + id / 8)) | (8'h01 << (id % 8));
            mem[longint'(CB + id - 32'd8192)] = cfg;
        end
    endtask

    task automatic clear_mon();
        pend_reads = 0;
        cfg_reads  = 0;
        order_err  = 0;
        range_err  = 0;
        last_cfg   = -1;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!scan_done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    typedef struct packed {
        logic [4:0]  sz;
        logic        sec;
        logic [31:0] id0;
        logic [7:0]  c0;
        logic [31:0] id1;
        logic [7:0]  c1;
        logic [31:0] id2;
        logic [7:0]  c2;
        logic        ev;
        logic [31:0] eid;
        logic [7:0]  ep;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R6: unshifted priority
        '{5'd13, 1'b1, 32'd8192, 8'hA1, 32'd0, 8'h00, 32'd0, 8'h00, 1'b1, 32'd8192, 8'hA0},
        // R7: remapped priority (0xA0>>1)|0x80
        '{5'd13, 1'b0, 32'd9000, 8'hA1, 32'd0, 8'h00, 32'd0, 8'h00, 1'b1, 32'd9000, 8'hD0},
        // R5: better-priority disabled entry ignored
        '{5'd13, 1'b1, 32'd8200, 8'h10, 32'd8300, 8'h41, 32'd0, 8'h00, 1'b1, 32'd8300, 8'h40},
        // R8: tie in one byte keeps lower ID
        '{5'd13, 1'b1, 32'd8205, 8'h21, 32'd8203, 8'h21, 32'd0, 8'h00, 1'b1, 32'd8203, 8'h20},
        // R3: last bit of the last byte wins
        '{5'd13, 1'b1, 32'd8500, 8'h81, 32'd16383, 8'h05, 32'd8193, 8'h85, 1'b1, 32'd16383, 8'h04},
        // R9: nothing enabled
        '{5'd13, 1'b0, 32'd10000, 8'h80, 32'd0, 8'h00, 32'd0, 8'h00, 1'b0, 32'd0, 8'hFF},
        // R9: nothing pending
        '{5'd13, 1'b1, 32'd0, 8'h00, 32'd0, 8'h00, 32'd0, 8'h00, 1'b0, 32'd0, 8'hFF},
        // R7: larger table, remap keeps order
        '{5'd14, 1'b0, 32'd8192, 8'h0D, 32'd20000, 8'h09, 32'd0, 8'h00, 1'b1, 32'd20000, 8'h84}
    };

    initial begin
        repeat (20000 * 9) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(scan_done == 1'b0, "R1 done in reset", scan_done, 0);
        check(win_valid == 1'b0, "R1 valid in reset", win_valid, 0);
        check(rd_req == 1'b0, "R1 req in reset", rd_req, 0);
        check(win_prio == 8'hFF, "R1 prio in reset", win_prio, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scan_done && !rd_req && win_prio == 8'hFF, "R1 after release", win_prio, 8'hFF);

        for (int v = 0; v < NV; v++) begin
            int n_ids;
            int exp_pend;
            mem.delete();
            put_irq(VECS[v].id0, VECS[v].c0);
            put_irq(VECS[v].id1, VECS[v].c1);
            put_irq(VECS[v].id2, VECS[v].c2);
            n_ids = (VECS[v].id0 != 0) + (VECS[v].id1 != 0) + (VECS[v].id2 != 0);
            exp_pend = (1 << (VECS[v].sz - 2)) - 1024;
            id_bits_m1 = VECS[v].sz;
            sec_off = VECS[v].sec;
            cfg_base = CB;
            clear_mon();
            pulse_start();
            wait_done();
            check(scan_done == 1'b1, "R9 done seen", scan_done, 1);
            check(win_valid == VECS[v].ev, "R9 valid", win_valid, VECS[v].ev);
            check(win_prio == VECS[v].ep, "R6 R7 prio", win_prio, VECS[v].ep);
            if (VECS[v].ev) check(win_id == VECS[v].eid, "R8 winner id", win_id, VECS[v].eid);
            @(negedge clk);
            check(scan_done == 1'b0, "R9 done one cycle", scan_done, 0);
            check(pend_reads == exp_pend && range_err == 0, "R3 bitmap reads", pend_reads, exp_pend);
            check(cfg_reads == n_ids && order_err == 0, "R4 config reads in order", cfg_reads, n_ids);
            repeat (5) @(negedge clk);
            check(win_prio == VECS[v].ep && win_valid == VECS[v].ev, "R9 result held", win_prio, VECS[v].ep);
        end

        // R2: table too small for any LPI; pending bit below 8192 is never read
        mem.delete();
        mem[longint'(PB + 32'd10)] = 8'hFF;
        id_bits_m1 = 5'd12;
        clear_mon();
        pulse_start();
        check(scan_done == 1'b1, "R2 immediate done", scan_done, 1);
        check(win_valid == 1'b0 && win_prio == 8'hFF, "R2 empty result", win_prio, 8'hFF);
        check(rd_req == 1'b0 && pend_reads == 0, "R2 no reads", pend_reads, 0);
        @(negedge clk);
        check(scan_done == 1'b0, "R2 done pulse ends", scan_done, 0);

        // R10: start during a scan is ignored
        mem.delete();
        put_irq(32'd12000, 8'h31);
        put_irq(32'd12001, 8'h21);
        id_bits_m1 = 5'd13;
        sec_off = 1'b1;
        cfg_base = CB;
        clear_mon();
        pulse_start();
        repeat (100) @(negedge clk);
        sec_off = 1'b0;
        cfg_base = CB2;
        pulse_start();
        wait_done();
        check(win_valid && win_id == 32'd12001, "R10 winner kept", win_id, 12001);
        check(win_prio == 8'h20, "R10 flag kept", win_prio, 8'h20);
        @(negedge clk);
        check(pend_reads == 1024, "R10 no restart", pend_reads, 1024);
        check(cfg_reads == 2, "R10 config base kept", cfg_reads, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule